// File: doc/BRIEF.md
# CCD Sensor Timing Generator

This block derives every digital drive strobe that an interline progressive-scan colour CCD needs from one master clock. It keeps a bit counter, a line counter and a field flag, and decodes them into line and frame sync, blanking flags, the complementary horizontal shift clocks, the reset gate pulse, the four vertical transfer phases, the two sensor readout strobes and the substrate drain pulse of the electronic shutter. Level shifting, the vertical driver and the analog front end sit outside.

The master clock `clk` runs at twice the horizontal bit rate (about 24.54 MHz for a 12.27 MHz bit rate). Each bit therefore has a first half and a second half, which lets the block form complementary horizontal clocks and a reset gate pulse within every bit. One line is 780 bits. In progressive mode a frame is 525 lines and both readout strobes fire once per frame. In monitoring mode fields of 263 and 262 lines alternate, the field flag toggles each field, and only the first strobe fires. The readout mode and the shutter line count are taken in only at a frame or field boundary.

Top module: `ccd_timing_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the generator at bit 0, first half, line 0, field 0. Directly after reset `hd`, `vd`, `hblank`, `vblank` and `h1` are 1, and `field`, `sg1`, `sg2` and `sub_pulse` are 0. `mon_mode` and `shutter_lines` are sampled during reset.
- R2: Each bit lasts two clocks: first half, then second half. A line is LINE_BITS bits (default 780). `hd` is 1 during bits 0 to HD_BITS-1 of every line.
- R3: `hblank` is 1 during bits 0 to HBLK_BITS-1 (default 140). In blanking `h1`=1, `h2`=0 and `rg`=0. Outside blanking `h1` and `rg` are 1 in the first half of each bit, and `h2` is 1 in the second half.
- R4: The phases {v1,v2a,v2b,v3} are 4'b0110 at rest. During bits V_START+k*V_STEP to V_START+(k+1)*V_STEP-1 they take 4'b0011 for k=0, 4'b1001 for k=1 and 4'b1100 for k=2. These steps fall inside blanking on every line.
- R5: When `mon_mode`=0 is latched (progressive), a frame is FRAME_LINES lines (default 525). `field` stays 0, and `vd` is 1 for all of line 0.
- R6: When `mon_mode`=1 is latched (monitoring), a field is ceil(FRAME_LINES/2) lines if `field`=0 and floor(FRAME_LINES/2) lines if `field`=1. `field` toggles at each boundary where monitoring is latched, and it returns to 0 when progressive is latched.
- R7: The readout line is the current frame or field length minus RD_BACK. On that line `sg1` is 1 for bits SG_START to SG_START+SG_BITS-1 (defaults 520 and 31). `sg2` matches `sg1` in progressive mode and stays 0 in monitoring mode.
- R8: `sub_pulse` is 1 during bits SUB_START to SUB_START+SUB_BITS-1 on each line L where L is below both the latched shutter count and the readout line. A count of 0 gives no pulse. Counts at or above the readout line are limited to it.
- R9: `mon_mode` and `shutter_lines` are latched only during reset and on the clock that wraps the generator back to line 0, bit 0. A change at any other time has no effect until that wrap.
- R10: `vblank` is 1 during lines 0 to VBLK_LINES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| mon_mode | input | 1 | 0 progressive, 1 monitoring; latched at frame boundary |
| shutter_lines | input | $clog2(FRAME_LINES+1) | Lines from frame start that receive a drain pulse |
| hd | output | 1 | Line sync |
| vd | output | 1 | Frame/field sync (line 0) |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| field | output | 1 | Field flag |
| h1 | output | 1 | Horizontal clock phase 1 |
| h2 | output | 1 | Horizontal clock phase 2 |
| rg | output | 1 | Reset gate pulse |
| v1 | output | 1 | Vertical phase 1 |
| v2a | output | 1 | Vertical phase 2A |
| v2b | output | 1 | Vertical phase 2B |
| v3 | output | 1 | Vertical phase 3 |
| sg1 | output | 1 | Readout strobe, merged on V2A |
| sg2 | output | 1 | Readout strobe, merged on V2B |
| sub_pulse | output | 1 | Substrate drain pulse |

## Verification
The assertions check, on every cycle, the relations that must hold whatever the frame position. The horizontal clocks toggle every clock outside blanking. The vertical phases hold still outside blanking. `sg2` never fires without `sg1`, and a drain pulse never overlaps a readout strobe or falls outside blanking. `field` and the latched mode change only on the wrap to line 0, and `hd` rises only after the last bit of a line. The bench scenarios are needed to show the things that depend on counting: frame and field lengths, which line is the readout line, how the shutter count is limited, and that a mode or shutter change made part-way through a frame waits for the next boundary.

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int LINE_BITS   = 780,
  parameter int HBLK_BITS   = 140,
  parameter int HD_BITS     = 64,
  parameter int SUB_START   = 40,
  parameter int SUB_BITS    = 20,
  parameter int V_START     = 60,
  parameter int V_STEP      = 16,
  parameter int SG_START    = 520,
  parameter int SG_BITS     = 31,
  parameter int FRAME_LINES = 525,
  parameter int RD_BACK     = 5,
  parameter int VBLK_LINES  = 10,
  localparam int LNW = $clog2(FRAME_LINES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mon_mode,
  input  logic [LNW-1:0] shutter_lines,
  output logic           hd,
  output logic           vd,
  output logic           hblank,
  output logic           vblank,
  output logic           field,
  output logic           h1,
  output logic           h2,
  output logic           rg,
  output logic           v1,
  output logic           v2a,
  output logic           v2b,
  output logic           v3,
  output logic           sg1,
  output logic           sg2,
  output logic           sub_pulse
);
  localparam int BW = $clog2(LINE_BITS + 1);
  localparam int MON_LONG  = (FRAME_LINES + 1) / 2;
  localparam int MON_SHORT = FRAME_LINES / 2;

  localparam logic [BW-1:0] B_LAST = BW'(LINE_BITS - 1);
  localparam logic [BW-1:0] B_HBLK = BW'(HBLK_BITS);
  localparam logic [BW-1:0] B_HD   = BW'(HD_BITS);
  localparam logic [BW-1:0] B_SUB0 = BW'(SUB_START);
  localparam logic [BW-1:0] B_SUB1 = BW'(SUB_START + SUB_BITS);
  localparam logic [BW-1:0] B_V0   = BW'(V_START);
  localparam logic [BW-1:0] B_V1   = BW'(V_START + V_STEP);
  localparam logic [BW-1:0] B_V2   = BW'(V_START + 2 * V_STEP);
  localparam logic [BW-1:0] B_V3   = BW'(V_START + 3 * V_STEP);
  localparam logic [BW-1:0] B_SG0  = BW'(SG_START);
  localparam logic [BW-1:0] B_SG1  = BW'(SG_START + SG_BITS);

  localparam logic [LNW-1:0] L_LAST_P = LNW'(FRAME_LINES - 1);
  localparam logic [LNW-1:0] L_LAST_L = LNW'(MON_LONG - 1);
  localparam logic [LNW-1:0] L_LAST_S = LNW'(MON_SHORT - 1);
  localparam logic [LNW-1:0] L_RD_P   = LNW'(FRAME_LINES - RD_BACK);
  localparam logic [LNW-1:0] L_RD_L   = LNW'(MON_LONG - RD_BACK);
  localparam logic [LNW-1:0] L_RD_S   = LNW'(MON_SHORT - RD_BACK);
  localparam logic [LNW-1:0] L_VBLK   = LNW'(VBLK_LINES);

  logic           half;
  logic [BW-1:0]  bitc;
  logic [LNW-1:0] line;
  logic           field_q;
  logic           mon_q;
  logic [LNW-1:0] shut_q;

  logic [LNW-1:0] last_line, rd_line;
  logic           bit_end, frame_end;

  assign last_line = !mon_q ? L_LAST_P : (field_q ? L_LAST_S : L_LAST_L);
  assign rd_line   = !mon_q ? L_RD_P   : (field_q ? L_RD_S   : L_RD_L);
  assign bit_end   = half && (bitc == B_LAST);
  assign frame_end = bit_end && (line == last_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      half    <= 1'b0;
      bitc    <= '0;
      line    <= '0;
      field_q <= 1'b0;
      mon_q   <= mon_mode;
      shut_q  <= shutter_lines;
    end else begin
      half <= ~half;
      if (bit_end)   bitc <= '0;
      else if (half) bitc <= bitc + BW'(1);
      if (bit_end)   line <= frame_end ? '0 : line + LNW'(1);
      if (frame_end) begin
        mon_q   <= mon_mode;
        shut_q  <= shutter_lines;
        field_q <= mon_mode ? ~field_q : 1'b0;
      end
    end
  end

  assign hblank = bitc < B_HBLK;
  assign hd     = bitc < B_HD;
  assign vd     = line == '0;
  assign vblank = line < L_VBLK;
  assign field  = field_q;

  assign h1 = hblank | ~half;
  assign h2 = ~hblank & half;
  assign rg = ~hblank & ~half;

  logic [3:0] vph;
  always_comb begin
    if (bitc >= B_V0 && bitc < B_V1)      vph = 4'b0011;
    else if (bitc >= B_V1 && bitc < B_V2) vph = 4'b1001;
    else if (bitc >= B_V2 && bitc < B_V3) vph = 4'b1100;
    else                                  vph = 4'b0110;
  end
  assign {v1, v2a, v2b, v3} = vph;

  logic rd_win;
  assign rd_win    = (line == rd_line) && (bitc >= B_SG0) && (bitc < B_SG1);
  assign sg1       = rd_win;
  assign sg2       = rd_win & ~mon_q;
  assign sub_pulse = (line < shut_q) && (line < rd_line) &&
                     (bitc >= B_SUB0) && (bitc < B_SUB1);

  logic wrap_now;
  assign wrap_now = (line == '0) && (bitc == '0) && !half;

  // R2
  hd_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hd) |-> ($past(half) && $past(bitc) == B_LAST));
  // R3
  h_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hblank && !$past(hblank)) |-> (h1 != $past(h1) && h2 != $past(h2)));
  // R4
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hblank && !$past(hblank)) |-> $stable({v1, v2a, v2b, v3}));
  // R7
  sg_pair_chk: assert property (@(posedge clk) disable iff (rst)
    sg2 |-> (sg1 && !hblank));
  // R8
  sub_place_chk: assert property (@(posedge clk) disable iff (rst)
    sub_pulse |-> (hblank && !sg1 && !sg2));
  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_now |-> $stable(field));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_now |-> ($stable(mon_q) && $stable(shut_q)));
endmodule

// File: tb/ccd_timing_gen_tb_top.sv
module ccd_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LB = 100, HB = 30, HDB = 4, SS = 6, SBW = 4;
  localparam int VS = 12, VST = 4, SGS = 60, SGW = 10;
  localparam int FL = 25, RB = 5, VBL = 3;
  localparam int LNW = $clog2(FL + 1);

  logic clk = 1'b0, rst = 1'b1, mon_mode = 1'b0;
  logic [LNW-1:0] shut_in = '0;
  logic hd, vd, hblank, vblank, field, h1, h2, rg, v1, v2a, v2b, v3, sg1, sg2, sub_pulse;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_half, m_bit, m_line;
  bit m_field, m_mon;
  int m_shut;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_timing_gen #(
    .LINE_BITS(LB), .HBLK_BITS(HB), .HD_BITS(HDB), .SUB_START(SS), .SUB_BITS(SBW),
    .V_START(VS), .V_STEP(VST), .SG_START(SGS), .SG_BITS(SGW),
    .FRAME_LINES(FL), .RD_BACK(RB), .VBLK_LINES(VBL)
  ) dut_i (
    .clk(clk), .rst(rst), .mon_mode(mon_mode), .shutter_lines(shut_in),
    .hd(hd), .vd(vd), .hblank(hblank), .vblank(vblank), .field(field),
    .h1(h1), .h2(h2), .rg(rg), .v1(v1), .v2a(v2a), .v2b(v2b), .v3(v3),
    .sg1(sg1), .sg2(sg2), .sub_pulse(sub_pulse)
  );

  task automatic check(input string tag, input string nm, input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (line %0d bit %0d half %0d)",
               tag, nm, got, exp, m_line, m_bit, m_half);
    end
  endtask

  function automatic int flen(bit mon, bit fld);
    if (!mon) return FL;
    return fld ? FL / 2 : (FL + 1) / 2;
  endfunction

  task automatic compare_all();
    int rd;
    bit e_hbl, e_sg1;
    logic [3:0] e_v;
    string pend;
    pend = (mon_mode != m_mon || int'(shut_in) != m_shut) ? " R9" : "";
    rd    = flen(m_mon, m_field) - RB;
    e_hbl = m_bit < HB;
    check({"R2", pend}, "hd", {3'b0, hd}, {3'b0, m_bit < HDB});
    check({"R3", pend}, "hblank", {3'b0, hblank}, {3'b0, e_hbl});
    check({"R3", pend}, "h1", {3'b0, h1}, {3'b0, e_hbl || m_half == 0});
    check({"R3", pend}, "h2", {3'b0, h2}, {3'b0, !e_hbl && m_half == 1});
    check({"R3", pend}, "rg", {3'b0, rg}, {3'b0, !e_hbl && m_half == 0});
    if (m_bit >= VS && m_bit < VS + VST)            e_v = 4'b0011;
    else if (m_bit >= VS + VST && m_bit < VS + 2*VST)   e_v = 4'b1001;
    else if (m_bit >= VS + 2*VST && m_bit < VS + 3*VST) e_v = 4'b1100;
    else                                            e_v = 4'b0110;
    check({"R4", pend}, "vphase", {v1, v2a, v2b, v3}, e_v);
    check({"R5", pend}, "vd", {3'b0, vd}, {3'b0, m_line == 0});
    check({"R6", pend}, "field", {3'b0, field}, {3'b0, m_field});
    e_sg1 = (m_line == rd) && m_bit >= SGS && m_bit < SGS + SGW;
    check({"R7", pend}, "sg1", {3'b0, sg1}, {3'b0, e_sg1});
    check({"R7", pend}, "sg2", {3'b0, sg2}, {3'b0, e_sg1 && !m_mon});
    check({"R8", pend}, "sub_pulse", {3'b0, sub_pulse},
          {3'b0, m_line < m_shut && m_line < rd && m_bit >= SS && m_bit < SS + SBW});
    check({"R10", pend}, "vblank", {3'b0, vblank}, {3'b0, m_line < VBL});
  endtask

  task automatic advance_model();
    int fl;
    m_half = 1 - m_half;
    if (m_half == 0) begin
      m_bit++;
      if (m_bit == LB) begin
        m_bit = 0;
        m_line++;
        fl = flen(m_mon, m_field);
        if (m_line == fl) begin
          m_line  = 0;
          m_field = mon_mode ? !m_field : 1'b0;
          m_mon   = mon_mode;
          m_shut  = int'(shut_in);
        end
      end
    end
  endtask

  task automatic run_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      advance_model();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic t_reset(input bit mon, input int shut);
    @(negedge clk);
    rst = 1'b1; mon_mode = mon; shut_in = LNW'(shut);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_half = 0; m_bit = 0; m_line = 0; m_field = 0; m_mon = mon; m_shut = shut;
    check("R1", "hd", {3'b0, hd}, 4'd1);
    check("R1", "vd", {3'b0, vd}, 4'd1);
    check("R1", "hblank", {3'b0, hblank}, 4'd1);
    check("R1", "vblank", {3'b0, vblank}, 4'd1);
    check("R1", "h1", {3'b0, h1}, 4'd1);
    check("R1", "field", {3'b0, field}, 4'd0);
    check("R1", "sg1", {3'b0, sg1}, 4'd0);
    check("R1", "sg2", {3'b0, sg2}, 4'd0);
    check("R1", "sub_pulse", {3'b0, sub_pulse}, 4'd0);
  endtask

  task automatic t_progressive();
    t_reset(1'b0, 7);
    run_clocks(2 * FL * LB * 2);
  endtask

  task automatic t_monitoring_midframe();
    int sg2_seen;
    run_clocks(7 * LB * 2 + 33);
    mon_mode = 1'b1; shut_in = LNW'(30);
    run_clocks(4 * FL * LB * 2);
    sg2_seen = 0;
    for (int i = 0; i < FL * LB * 2; i++) begin
      @(posedge clk); advance_model(); @(negedge clk); compare_all();
      if (sg2) sg2_seen++;
    end
    check("R7", "sg2 count in monitoring", 4'(sg2_seen), 4'd0);
  endtask

  task automatic t_back_to_progressive();
    run_clocks(3 * LB * 2 + 11);
    mon_mode = 1'b0; shut_in = '0;
    run_clocks(3 * FL * LB * 2);
  endtask

  task automatic t_monitoring_from_reset();
    t_reset(1'b1, 2);
    run_clocks(3 * FL * LB * 2);
  endtask

  initial begin
    t_progressive();
    t_monitoring_midframe();
    t_back_to_progressive();
    t_monitoring_from_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule